// File: doc/BRIEF.md
# Event Packet Framer with Running CRC

This block builds one event packet as a stream of 32-bit words. A start pulse captures a set of header words and a set of trigger-summary words from parallel inputs. The framer then sends the header words, then collects and sends one hit block per sensor, each block opened by a word holding its hit count. After the last sensor block it sends a fixed separator word, the trigger-summary words, a CRC word over everything sent before it, and a fixed closing word.

Hits for each sensor arrive on a valid/ready stream and are buffered locally, because the count word must go out ahead of the hits. A sensor with no hits is announced by a single beat that carries the "no hits" flag. The output is a valid/ready stream with a last flag on the closing word. The downstream side may stall it at any point.

Top module: `evt_pkt_framer`

## Requirements
- R1: After reset, `out_valid`, `out_last` and `hit_ready` are low, and the block waits for `pkt_start`.
- R2: The packet opens with the HDR_WORDS header words, sent in index order. Word i is `hdr_words[32*i +: 32]`, captured in the cycle that `pkt_start` is accepted.
- R3: Sensor blocks follow in arrival order. Each block is one word holding the sensor's hit count, then that many hit words in arrival order. A sensor's hits end at the beat with `hit_last` high.
- R4: A beat with `hit_valid` and `hit_none` high ends the current sensor with no hits. That sensor's block is a single count word of 0, and the beat's data is not sent.
- R5: The word 0xCCCCCCCC directly follows the last sensor block.
- R6: The TSUM_WORDS trigger-summary words follow the separator, in index order. Word i is `tsum_words[32*i +: 32]`, captured together with the header.
- R7: The next word is a CRC-32 over every earlier word of the packet. It uses polynomial 0x04C11DB7 and an all-ones start value. Each word is processed MSB first, with no bit reflection and no final XOR. The CRC starts again from all ones for every packet.
- R8: The word 0xBBBBBBBB closes the packet, and it is the only word sent with `out_last` high.
- R9: While `out_valid` is high and `out_ready` is low, the output word stays the same. Stalls of any length or pattern leave the packet contents, including the CRC, unchanged.
- R10: A `pkt_start` pulse or a change of `hdr_words` or `tsum_words` has no effect while a packet is in progress.
- R11: `hit_ready` is high only while a sensor's hits are being collected. Each sensor may deliver up to MAX_HITS hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_start | input | 1 | Starts a packet when the block is idle |
| hdr_words | input | 32*HDR_WORDS | Header words, word 0 in the low bits |
| tsum_words | input | 32*TSUM_WORDS | Trigger-summary words, word 0 in the low bits |
| hit_valid | input | 1 | Hit beat present |
| hit_ready | output | 1 | Framer accepts a hit beat |
| hit_data | input | 32 | Hit address word |
| hit_last | input | 1 | Last hit of the current sensor |
| hit_none | input | 1 | Current sensor has no hits; data ignored |
| out_data | output | 32 | Packet word |
| out_valid | output | 1 | Packet word present |
| out_ready | input | 1 | Downstream accepts the word |
| out_last | output | 1 | Closing word of the packet |

## Verification
The assertions assume that no sensor delivers more than MAX_HITS hits. The stimulus keeps every sensor at or below that limit, and one test reaches it exactly. The assertions also assume that the header and summary inputs matter only in the cycle a start is accepted. The bench changes those inputs and pulses start in the middle of a packet, and it checks that the packet comes out unchanged. Stalls are applied as an irregular `out_ready` pattern while hits arrive at the same time as output is being sent.

// File: rtl/framer_pkg.sv
// Shared definitions for the event packet framer: state encoding,
// fixed marker words and the one-word CRC-32 step.
// Assumes CRC processing is MSB first with no reflection.
package framer_pkg;

    localparam logic [31:0] SEP_WORD  = 32'hCCCC_CCCC;
    localparam logic [31:0] END_WORD  = 32'hBBBB_BBBB;
    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;

    typedef enum logic [3:0] {
        ST_IDLE, ST_HDR, ST_COLLECT, ST_LEN, ST_HITS,
        ST_SEP, ST_TSUM, ST_CRC, ST_END
    } fr_state_t;

    // Advances a CRC-32 register by one 32-bit word, MSB first.
    function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                               input logic [31:0] word);
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int b = 31; b >= 0; b--) begin
            fb = c[31] ^ word[b];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/pkt_crc32.sv
// Running CRC-32 register. Reloads the seed on init and absorbs one
// word per cycle on upd. Assumes init and upd are never high together.
module pkt_crc32
    import framer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        upd,
    input  logic [31:0] data,
    output logic [31:0] crc
);

    // Holds the running remainder; keeps its value when neither control is set.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc <= CRC_SEED;
        else if (init) crc <= CRC_SEED;
        else if (upd)  crc <= crc32_step(crc, data);
    end

    assert_ctrl_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(init && upd));

endmodule

// File: rtl/hit_store.sv
// Buffers one sensor's hits so that their count can be sent ahead of them.
// Writes go to the next free slot. Reads are combinational by address.
// Assumes the writer never exceeds DEPTH entries between clears.
module hit_store #(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata,
    output logic [CW-1:0] count
);

    logic [31:0] mem [DEPTH];

    // Stores an incoming hit at the current fill position.
    always_ff @(posedge clk) begin
        if (we) mem[count[AW-1:0]] <= wdata;
    end

    // Tracks how many hits are held for the current sensor.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (we)  count <= count + 1'b1;
    end

    assign rdata = mem[raddr];

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (count < CW'(DEPTH)));

endmodule

// File: rtl/evt_pkt_framer.sv
// Event packet framer. Sends the header words, one length-prefixed hit
// block per sensor, a separator, the trigger-summary words, a CRC over
// all earlier words and a closing word. The output is a valid/ready stream.
// Assumes each sensor sends at most MAX_HITS hits.
module evt_pkt_framer
    import framer_pkg::*;
#(
    parameter int NUM_SENSORS = 3,
    parameter int HDR_WORDS   = 8,
    parameter int TSUM_WORDS  = 2,
    parameter int MAX_HITS    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pkt_start,
    input  logic [32*HDR_WORDS-1:0] hdr_words,
    input  logic [32*TSUM_WORDS-1:0] tsum_words,
    input  logic                    hit_valid,
    output logic                    hit_ready,
    input  logic [31:0]             hit_data,
    input  logic                    hit_last,
    input  logic                    hit_none,
    output logic [31:0]             out_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic                    out_last
);

    localparam int MAXN = (HDR_WORDS > TSUM_WORDS) ?
                          ((HDR_WORDS > MAX_HITS) ? HDR_WORDS : MAX_HITS) :
                          ((TSUM_WORDS > MAX_HITS) ? TSUM_WORDS : MAX_HITS);
    localparam int IW = $clog2(MAXN + 1);
    localparam int AW = (MAX_HITS > 1) ? $clog2(MAX_HITS) : 1;
    localparam int CW = $clog2(MAX_HITS + 1);
    localparam int SW = (NUM_SENSORS > 1) ? $clog2(NUM_SENSORS) : 1;

    fr_state_t                state;
    logic [IW-1:0]            idx;
    logic [SW-1:0]            sens;
    logic [32*HDR_WORDS-1:0]  hdr_q;
    logic [32*TSUM_WORDS-1:0] tsum_q;
    logic [31:0]              crc;
    logic [31:0]              hit_rd;
    logic [CW-1:0]            hit_cnt;
    logic                     fire;
    logic                     take_hit;
    logic                     blk_done;
    logic                     clr_store;

    assign fire      = out_valid && out_ready;
    assign hit_ready = (state == ST_COLLECT);
    assign take_hit  = hit_ready && hit_valid;
    assign blk_done  = fire && (((state == ST_LEN) && (hit_cnt == '0)) ||
                       ((state == ST_HITS) && (IW'(hit_cnt) == idx + 1'b1)));
    assign clr_store = blk_done || (state == ST_IDLE);

    // Buffer for the hits of the sensor being collected.
    hit_store #(.DEPTH(MAX_HITS)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_store),
        .we    (take_hit && !hit_none),
        .wdata (hit_data),
        .raddr (idx[AW-1:0]),
        .rdata (hit_rd),
        .count (hit_cnt)
    );

    // Running CRC over every word sent before the CRC word.
    pkt_crc32 crc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .init  ((state == ST_IDLE) && pkt_start),
        .upd   (fire && (state != ST_CRC) && (state != ST_END)),
        .data  (out_data),
        .crc   (crc)
    );

    // Selects the word to present for the current state.
    always_comb begin
        out_valid = 1'b1;
        out_last  = 1'b0;
        out_data  = '0;
        unique case (state)
            ST_HDR:  out_data = hdr_q[32*idx +: 32];
            ST_LEN:  out_data = 32'(hit_cnt);
            ST_HITS: out_data = hit_rd;
            ST_SEP:  out_data = SEP_WORD;
            ST_TSUM: out_data = tsum_q[32*idx +: 32];
            ST_CRC:  out_data = crc;
            ST_END: begin
                out_data = END_WORD;
                out_last = 1'b1;
            end
            default: out_valid = 1'b0;
        endcase
    end

    // Sequences the packet and captures the parallel fields at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx    <= '0;
            sens   <= '0;
            hdr_q  <= '0;
            tsum_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (pkt_start) begin
                    hdr_q  <= hdr_words;
                    tsum_q <= tsum_words;
                    idx    <= '0;
                    sens   <= '0;
                    state  <= ST_HDR;
                end
                ST_HDR: if (fire) begin
                    if (idx == IW'(HDR_WORDS - 1)) begin
                        idx   <= '0;
                        state <= ST_COLLECT;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_COLLECT: if (take_hit && (hit_last || hit_none)) state <= ST_LEN;
                ST_LEN: if (fire) begin
                    idx <= '0;
                    if (hit_cnt != '0) state <= ST_HITS;
                end
                ST_HITS: if (fire && !blk_done) idx <= idx + 1'b1;
                ST_SEP: if (fire) begin
                    idx   <= '0;
                    state <= ST_TSUM;
                end
                ST_TSUM: if (fire) begin
                    if (idx == IW'(TSUM_WORDS - 1)) state <= ST_CRC;
                    else                            idx <= idx + 1'b1;
                end
                ST_CRC: if (fire) state <= ST_END;
                ST_END: if (fire) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
            if (blk_done) begin
                idx <= '0;
                if (sens == SW'(NUM_SENSORS - 1)) begin
                    state <= ST_SEP;
                end else begin
                    sens  <= sens + 1'b1;
                    state <= ST_COLLECT;
                end
            end
        end
    end

    assert_hold_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_last_marker_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && out_data == END_WORD));

    assert_crc_fresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR && idx == '0) |-> (crc == CRC_SEED));

    assert_ports_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_ready && out_valid));

    assert_sep_after_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_SEP) |-> (out_data == SEP_WORD && $past(fire)));

endmodule

// File: tb/evt_pkt_framer_tb.sv
// Directed bench for the event packet framer. Each task runs one packet
// scenario, builds the expected words from the requirements and compares.
module evt_pkt_framer_tb_top;

    localparam int NS = 3;
    localparam int HW = 8;
    localparam int TW = 2;
    localparam int MH = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pkt_start = 1'b0;
    logic [32*HW-1:0] hdr_words = '0;
    logic [32*TW-1:0] tsum_words = '0;
    logic            hit_valid = 1'b0;
    logic            hit_ready;
    logic [31:0]     hit_data = '0;
    logic            hit_last = 1'b0;
    logic            hit_none = 1'b0;
    logic [31:0]     out_data;
    logic            out_valid;
    logic            out_ready = 1'b0;
    logic            out_last;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    int          nh [NS];
    logic [31:0] hv [NS][MH];
    logic [31:0] got [$];
    logic        got_last [$];
    int          hold_bad;

    evt_pkt_framer #(.NUM_SENSORS(NS), .HDR_WORDS(HW), .TSUM_WORDS(TW),
                     .MAX_HITS(MH)) dut_i (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start),
        .hdr_words(hdr_words), .tsum_words(tsum_words),
        .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_data(hit_data),
        .hit_last(hit_last), .hit_none(hit_none),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_last(out_last)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] ref_crc(input logic [31:0] c0, input logic [31:0] w);
        logic [31:0] c;
        c = c0;
        for (int b = 31; b >= 0; b--) begin
            if (c[31] ^ w[b]) c = {c[30:0], 1'b0} ^ 32'h04C11DB7;
            else              c = {c[30:0], 1'b0};
        end
        return c;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Sends every sensor's hits; a sensor with no hits gets one "none" beat.
    task automatic produce();
        for (int s = 0; s < NS; s++) begin
            int n;
            n = (nh[s] == 0) ? 1 : nh[s];
            for (int k = 0; k < n; k++) begin
                hit_valid = 1'b1;
                hit_none  = (nh[s] == 0);
                hit_data  = (nh[s] == 0) ? 32'hDEAD_0000 : hv[s][k];
                hit_last  = (k == n - 1) && (nh[s] != 0);
                forever begin
                    if (hit_ready) begin
                        @(negedge clk);
                        break;
                    end
                    @(negedge clk);
                end
            end
            hit_valid = 1'b0;
            hit_none  = 1'b0;
            hit_last  = 1'b0;
            @(negedge clk);
        end
    endtask

    // Collects output words until the closing word; mode 1 stalls irregularly.
    task automatic consume(input int mode);
        int t;
        logic [31:0] prev;
        logic prev_stall;
        t = 0;
        prev_stall = 1'b0;
        prev = '0;
        forever begin
            logic r;
            if (prev_stall && out_valid && out_data != prev) hold_bad++;
            r = (mode == 0) ? 1'b1 : ((t % 3) != 1 && (t % 7) != 3);
            out_ready = r;
            prev_stall = out_valid && !r;
            prev = out_data;
            if (out_valid && r) begin
                got.push_back(out_data);
                got_last.push_back(out_last);
                if (out_last) begin
                    @(negedge clk);
                    out_ready = 1'b0;
                    break;
                end
            end
            t++;
            @(negedge clk);
        end
    endtask

    task automatic start_pkt(input logic [32*HW-1:0] h, input logic [32*TW-1:0] ts);
        @(negedge clk);
        hdr_words  = h;
        tsum_words = ts;
        pkt_start  = 1'b1;
        @(negedge clk);
        pkt_start  = 1'b0;
    endtask

    // Pulses start and scrambles the fields while a packet is running.
    task automatic disturb();
        repeat (12) @(negedge clk);
        hdr_words  = {HW{32'h5A5A_5A5A}};
        tsum_words = {TW{32'hA5A5_A5A5}};
        pkt_start  = 1'b1;
        @(negedge clk);
        pkt_start  = 1'b0;
    endtask

    // Runs one packet and compares every word against the expected stream.
    task automatic run_pkt(input string name, input int mode, input bit mid,
                           input logic [31:0] seed);
        logic [32*HW-1:0] h;
        logic [32*TW-1:0] ts;
        logic [31:0] exp [$];
        string tag [$];
        logic [31:0] c;
        for (int i = 0; i < HW; i++) h[32*i +: 32] = seed + 32'h100 * i;
        for (int i = 0; i < TW; i++) ts[32*i +: 32] = ~seed ^ i;
        for (int i = 0; i < HW; i++) begin exp.push_back(h[32*i +: 32]); tag.push_back("R2 header"); end
        for (int s = 0; s < NS; s++) begin
            exp.push_back(nh[s]);
            tag.push_back(nh[s] == 0 ? "R4 empty length" : "R3 length");
            for (int k = 0; k < nh[s]; k++) begin exp.push_back(hv[s][k]); tag.push_back("R3 hit"); end
        end
        exp.push_back(32'hCCCC_CCCC); tag.push_back("R5 separator");
        for (int i = 0; i < TW; i++) begin exp.push_back(ts[32*i +: 32]); tag.push_back("R6 summary"); end
        c = 32'hFFFF_FFFF;
        foreach (exp[i]) c = ref_crc(c, exp[i]);
        exp.push_back(c); tag.push_back(mode ? "R9 R7 crc under stall" : "R7 crc");
        exp.push_back(32'hBBBB_BBBB); tag.push_back("R8 ender");
        got.delete();
        got_last.delete();
        hold_bad = 0;
        start_pkt(h, ts);
        fork
            produce();
            consume(mode);
            if (mid) disturb();
        join
        chk(got.size() == exp.size(), {name, " word count"}, got.size(), exp.size());
        if (got.size() == exp.size()) begin
            foreach (exp[i]) begin
                chk(got[i] == exp[i], {name, " ", tag[i], (mid ? " R10" : "")}, got[i], exp[i]);
                chk(got_last[i] == (i == exp.size() - 1), {name, " R8 last flag"},
                    got_last[i], (i == exp.size() - 1));
            end
        end
        chk(hold_bad == 0, {name, " R9 hold"}, hold_bad, 0);
        chk(!hit_ready && !out_valid, {name, " R11 idle after packet"},
            {hit_ready, out_valid}, 0);
    endtask

    task automatic set_hits(input int a, input int b, input int d, input logic [31:0] base);
        nh[0] = a; nh[1] = b; nh[2] = d;
        for (int s = 0; s < NS; s++)
            for (int k = 0; k < MH; k++) hv[s][k] = base + (s << 8) + k * 3;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(out_last == 1'b0, "R1 out_last", out_last, 0);
        chk(hit_ready == 1'b0, "R1 hit_ready", hit_ready, 0);
    endtask

    task automatic t_basic();     set_hits(2, 3, 1, 32'h1000_0000); run_pkt("basic", 0, 0, 32'h0A00_0001); endtask
    task automatic t_empty();     set_hits(0, 2, 0, 32'h2000_0000); run_pkt("empty", 0, 0, 32'h0B00_0002); endtask
    task automatic t_stall();     set_hits(4, 1, 3, 32'h3000_0000); run_pkt("stall", 1, 0, 32'h0C00_0003); endtask
    task automatic t_midstart();  set_hits(1, 1, 2, 32'h4000_0000); run_pkt("midstart", 1, 1, 32'h0D00_0004); endtask
    task automatic t_full();      set_hits(MH, 0, MH, 32'h5000_0000); run_pkt("full R11", 0, 0, 32'h0E00_0005); endtask
    task automatic t_again();     set_hits(2, 3, 1, 32'h1000_0000); run_pkt("repeat R7", 1, 0, 32'h0A00_0001); endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual %0d expected below 100000", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_empty();
        t_stall();
        t_midstart();
        t_full();
        t_again();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule